// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block divides the free-running oscillator clock down to a slow periodic tick and raises an interrupt request at the end of every period. Software picks the period with a 7-bit rate code that has two fields: a 3-bit exponent `n` and a 4-bit modulus `m`. One period lasts (m+1)·2^(n+9) oscillator cycles. An exponent of zero switches the timer off. Each period end sets a sticky flag. Software clears the flag by writing a one to it. An enable bit decides whether the flag reaches the interrupt output.

The block is programmed through a small write-only register port with four addresses: rate, flag, enable and low-power control. Two mode inputs report when the chip is in wait or pseudo-stop. Two control bits decide whether the timer halts in those modes. When the timer halts in wait mode, its dividers are also reloaded.

Top module: `rti_timer`

## Requirements
- R1: While the exponent field (rate register, address 0, bits 6..4) is 0, the timer is off and the flag never sets.
- R2: After a write of rate code {n, m} (m in bits 3..0), the flag first rises exactly (m+1)·2^(n+9) clock cycles after the clock edge that samples the write.
- R3: Periods follow each other with no dead cycle, so the flag sets again every (m+1)·2^(n+9) cycles after the first period end.
- R4: Writing a 1 to bit 7 of the flag register (address 1) clears the flag.
- R5: The interrupt output equals the flag while bit 7 of the enable register (address 2) is 1, and is 0 while that bit is 0.
- R6: With the stop-in-wait bit (address 3, bit 1) set, asserting wait mode halts the timer and reloads its dividers. A full new period starts after the last cycle in which wait mode is sampled high.
- R7: In pseudo-stop mode the timer halts and holds its count when the run-in-pseudo-stop bit (address 3, bit 0) is 0, and keeps counting when that bit is 1.
- R8: After reset the rate code, enable, control bits and flag are all 0, and the interrupt output is 0.
- R9: Writing 0 to bit 7 of the flag register leaves the flag unchanged.
- R10: If a period ends in the same cycle as a flag-clear write, the flag ends up set.
- R11: Any write to the rate register restarts the current period from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 rate, 1 flag, 2 enable, 3 low-power control |
| regWrData | input | 8 | Write data |
| waitMode | input | 1 | Chip is in wait mode |
| pseudoStop | input | 1 | Chip is in pseudo-stop mode |
| rtiFlag | output | 1 | Sticky period-end flag |
| rtiIrq | output | 1 | Interrupt request: the flag gated by the enable bit |

## Verification
Some rules are checked by the assertions on every cycle. A period end always sets the flag on the next edge. A clear write with no coincident period end always empties the flag. A zero write leaves the flag unchanged. A zero exponent never produces a period end. A restart strobe zeroes both dividers. A halted, unrestarted timer holds its count. Only the bench scenarios can show the exact period lengths for several {n, m} codes, the spacing between back-to-back periods, the restart on a rate write, and how much a low-power interval stretches or reloads a period. The bench also shows the gating of the interrupt by the enable bit. The set-over-clear case is driven on purpose in the exact cycle of a period end.

// File: rtl/rti_pkg.sv
package rti_pkg;
  // register addresses on the write port
  localparam logic [1:0] ADDR_RATE = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_ENAB = 2'd2;
  localparam logic [1:0] ADDR_LPWR = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic restart; // zero both dividers
    logic run;     // advance the dividers this cycle
  } dpCtrl_t;
endpackage

// File: rtl/rti_datapath.sv
module rti_datapath
  import rti_pkg::*;
#(
  parameter int BASE_SHIFT = 9,
  parameter int N_W        = 3,
  parameter int M_W        = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtrl_t        ctrl,
  input  logic [N_W-1:0] rateN,
  input  logic [M_W-1:0] rateM,
  output logic           periodEnd
);
  localparam int PRE_W = BASE_SHIFT + (1 << N_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [M_W-1:0]   modCnt;
  logic             preTick;

  // prescaler terminal value: 2^(n+BASE_SHIFT)-1
  always_comb begin
    for (int i = 0; i < PRE_W; i++)
      preMask[i] = (i < (int'(rateN) + BASE_SHIFT));
  end

  assign preTick   = ctrl.run && (preCnt == preMask);
  assign periodEnd = preTick && (modCnt == rateM);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.restart) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (ctrl.run) begin
      if (preTick) begin
        preCnt <= '0;
        modCnt <= (modCnt == rateM) ? '0 : modCnt + M_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restart |=> (preCnt == '0) && (modCnt == '0));

  // R7
  hold_when_halted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.run && !ctrl.restart) |=> $stable(preCnt) && $stable(modCnt));
endmodule

// File: rtl/rti_control.sv
module rti_control
  import rti_pkg::*;
#(
  parameter int N_W    = 3,
  parameter int M_W    = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              waitMode,
  input  logic              pseudoStop,
  input  logic              periodEnd,
  output dpCtrl_t           ctrl,
  output logic [N_W-1:0]    rateN,
  output logic [M_W-1:0]    rateM,
  output logic              flagQ,
  output logic              irqOut
);
  localparam int TOP_BIT = DATA_W - 1;

  logic enableQ, stopInWaitQ, runInPseudoQ;
  logic rateWr, flagClr, flagZeroWr, waitHalt, pseudoHalt;

  assign rateWr     = regWrEn && (regAddr == ADDR_RATE);
  assign flagClr    = regWrEn && (regAddr == ADDR_FLAG) && regWrData[TOP_BIT];
  assign flagZeroWr = regWrEn && (regAddr == ADDR_FLAG) && !regWrData[TOP_BIT];
  assign waitHalt   = waitMode && stopInWaitQ;
  assign pseudoHalt = pseudoStop && !runInPseudoQ;

  always_comb begin
    ctrl.restart = rateWr || (rateN == '0) || waitHalt;
    ctrl.run     = (rateN != '0) && !waitHalt && !pseudoHalt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateN        <= '0;
      rateM        <= '0;
      enableQ      <= 1'b0;
      stopInWaitQ  <= 1'b0;
      runInPseudoQ <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_RATE: begin
          rateN <= regWrData[M_W +: N_W];
          rateM <= regWrData[M_W-1:0];
        end
        ADDR_ENAB: enableQ <= regWrData[TOP_BIT];
        ADDR_LPWR: begin
          stopInWaitQ  <= regWrData[1];
          runInPseudoQ <= regWrData[0];
        end
        default: ;
      endcase
    end
  end

  // set takes priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)          flagQ <= 1'b0;
    else if (periodEnd) flagQ <= 1'b1;
    else if (flagClr)   flagQ <= 1'b0;
  end

  assign irqOut = flagQ && enableQ;

  // R2
  set_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> flagQ);

  // R4
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !periodEnd) |=> !flagQ);

  // R9
  zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagZeroWr && !periodEnd) |=> $stable(flagQ));

  // R1
  off_no_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateN == '0) |-> !periodEnd);
endmodule

// File: rtl/rti_timer.sv
module rti_timer
  import rti_pkg::*;
#(
  parameter int BASE_SHIFT = 9,
  parameter int N_W        = 3,
  parameter int M_W        = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              waitMode,
  input  logic              pseudoStop,
  output logic              rtiFlag,
  output logic              rtiIrq
);
  dpCtrl_t        ctrl;
  logic [N_W-1:0] rateN;
  logic [M_W-1:0] rateM;
  logic           periodEnd;

  rti_control #(.N_W(N_W), .M_W(M_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .waitMode(waitMode), .pseudoStop(pseudoStop),
    .periodEnd(periodEnd), .ctrl(ctrl), .rateN(rateN), .rateM(rateM),
    .flagQ(rtiFlag), .irqOut(rtiIrq)
  );

  rti_datapath #(.BASE_SHIFT(BASE_SHIFT), .N_W(N_W), .M_W(M_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rateN(rateN), .rateM(rateM),
    .periodEnd(periodEnd)
  );
endmodule

// File: tb/rti_timer_bench.sv
module rti_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic       waitMode = 1'b0;
  logic       pseudoStop = 1'b0;
  logic       rtiFlag, rtiIrq;

  int  cyc = 0;
  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 1'b0;
  bit  prevFlag = 1'b0;

  typedef struct { int when; string tag; } expRise_t;
  expRise_t expQ[$];

  rti_timer u_rti_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .waitMode(waitMode), .pseudoStop(pseudoStop),
    .rtiFlag(rtiFlag), .rtiIrq(rtiIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectRise(int when, string tag);
    expRise_t e;
    e.when = when; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitUntil(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: every flag rise must match the head of the queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rtiFlag && !prevFlag) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected flag rise", cyc, -1);
        end else begin
          expRise_t e;
          e = expQ.pop_front();
          check(cyc == e.when, e.tag, cyc, e.when);
        end
      end
      prevFlag <= rtiFlag;
    end
  end

  initial begin
    int w;
    repeat (5) @(negedge clk);
    check(rtiFlag == 1'b0, "R8 flag after reset", rtiFlag, 0);
    check(rtiIrq == 1'b0, "R8 irq after reset", rtiIrq, 0);
    rstN = 1'b1;
    @(negedge clk);
    writeReg(2'd2, 8'h80);               // enable interrupt
    repeat (3000) @(negedge clk);
    check(rtiFlag == 1'b0, "R1 R8 off after reset", rtiFlag, 0);

    // n=1 m=0 -> 1024 cycles
    writeReg(2'd0, 8'h10); w = cyc;
    expectRise(w + 1024, "R2 first period n1 m0");
    expectRise(w + 2048, "R3 back-to-back period");
    waitUntil(w + 1024);
    check(rtiIrq == 1'b1, "R5 irq follows flag", rtiIrq, 1);
    writeReg(2'd1, 8'h80);
    check(rtiFlag == 1'b0, "R4 clear by writing one", rtiFlag, 0);
    waitUntil(w + 2048);
    writeReg(2'd1, 8'h00);
    check(rtiFlag == 1'b1, "R9 zero write ignored", rtiFlag, 1);
    writeReg(2'd1, 8'h80);
    // clear sampled in the same edge as the period end
    expectRise(w + 3072, "R3 third period");
    waitUntil(w + 3071);
    writeReg(2'd1, 8'h80);
    check(rtiFlag == 1'b1, "R10 set wins over clear", rtiFlag, 1);
    writeReg(2'd1, 8'h80);
    // enable off
    writeReg(2'd2, 8'h00);
    expectRise(w + 4096, "R3 fourth period");
    waitUntil(w + 4096);
    check(rtiIrq == 1'b0, "R5 irq masked", rtiIrq, 0);
    check(rtiFlag == 1'b1, "R5 flag still set when masked", rtiFlag, 1);
    writeReg(2'd1, 8'h80);
    writeReg(2'd2, 8'h80);

    // mid-period rewrite restarts; n=1 m=1 -> 2048
    waitUntil(w + 4600);
    writeReg(2'd0, 8'h11); w = cyc;
    expectRise(w + 2048, "R11 R2 restart n1 m1");
    waitUntil(w + 2048);
    writeReg(2'd1, 8'h80);

    // n=2 m=0 -> 2048
    writeReg(2'd0, 8'h20); w = cyc;
    expectRise(w + 2048, "R2 n2 m0");
    waitUntil(w + 2048);
    writeReg(2'd1, 8'h80);

    // wait mode with stop-in-wait
    writeReg(2'd3, 8'h02);
    writeReg(2'd0, 8'h10); w = cyc;
    waitUntil(w + 500);
    waitMode = 1'b1; w = cyc;
    repeat (300) @(negedge clk);
    waitMode = 1'b0;
    expectRise(w + 300 + 1024, "R6 reload after wait");
    waitUntil(w + 1324);
    writeReg(2'd1, 8'h80);

    // pseudo-stop halts
    writeReg(2'd3, 8'h00);
    writeReg(2'd0, 8'h10); w = cyc;
    expectRise(w + 1224, "R7 halted in pseudo-stop");
    waitUntil(w + 400);
    pseudoStop = 1'b1;
    repeat (200) @(negedge clk);
    pseudoStop = 1'b0;
    waitUntil(w + 1224);
    writeReg(2'd1, 8'h80);

    // pseudo-stop keeps running
    writeReg(2'd3, 8'h01);
    writeReg(2'd0, 8'h10); w = cyc;
    expectRise(w + 1024, "R7 running in pseudo-stop");
    waitUntil(w + 400);
    pseudoStop = 1'b1;
    repeat (200) @(negedge clk);
    pseudoStop = 1'b0;
    waitUntil(w + 1024);
    writeReg(2'd1, 8'h80);

    // n=0 with nonzero m: off
    writeReg(2'd0, 8'h05);
    repeat (3000) @(negedge clk);
    check(rtiFlag == 1'b0, "R1 exponent zero off", rtiFlag, 0);
    check(expQ.size() == 0, "R2 all expected rises seen", expQ.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule